// File: doc/BRIEF.md
# Masked Sticky-Pending Interrupt Controller

This block gathers thirty-two level-sensitive interrupt lines into one request for a small processor. Each line is brought into the clock domain and kept in a line-state register. Any line that is high sets a bit in a pending register. That bit stays set until software acknowledges it. A mask register decides which pending bits may raise the processor request. The request is registered, so it changes on the clock edge that follows its cause.

Software uses a simple register port. It can write the mask and read it back. It acknowledges pending bits by writing ones to the pending address. The line state can be read. A per-line assertion counter can be read through a line index. An acknowledge does not hold while its line is still high, because the pending bit is set again from the line state. Each counter advances on every rising edge of its synchronized line, whatever the mask holds, and wraps around at its width.

Top module: `irqc_top`

## Requirements
- R1: Reading address 2 returns the line-state vector. Each bit shows its input level after the two-flop synchronizer and one further register, three clock edges after the input changes.
- R2: A pending bit, once set, stays set while no acknowledge write clears it, even after its line returns low.
- R3: A write to address 1 clears each pending bit written as 1 whose line state is low. Bits written as 0 are unchanged. Reading address 1 returns the pending vector.
- R4: An acknowledged bit whose line state is still high is pending again after that same write edge.
- R5: `irq_o` is 1 exactly when the registered pending AND mask is non-zero. It changes on the same edge as the pending or mask register that causes it.
- R6: A write to address 0 replaces all mask bits. Reading address 0 returns the mask, and `irq_o` reflects the new mask after the write edge.
- R7: While reset is low, `irq_o`, the mask, the pending register, the line state and every counter read 0.
- R8: Reading address 3 returns the counter of the line chosen by `cnt_idx_i`. That counter adds one for each rising edge of its line state, whatever the mask holds.
- R9: Writes to addresses 2 and 3 change no register.
- R10: When an acknowledge of a bit reaches the same edge at which that line's assertion is first taken into pending, the bit stays pending, even if the line has since returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines_i | input | NUM_LINES | Asynchronous interrupt line levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 pending, 2 line state, 3 counter |
| reg_wdata_i | input | DATA_W | Write data |
| cnt_idx_i | input | $clog2(NUM_LINES) | Line whose counter is read at address 3 |
| reg_rdata_o | output | DATA_W | Read data for the selected register, combinational |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
An acknowledge write and the capture of a fresh line assertion into pending can reach the same clock edge. The bench drives a pulse exactly one clock long on one line. It counts the synchronizer and line-state stages to place the acknowledge on the single edge where the line state is high and the pending bit is first set. After the line has fallen, the pending bit must still read 1. Design variants that apply the acknowledge after the new assertion leave it at 0 and are caught.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    REG_MASK  = 2'd0,
    REG_PEND  = 2'd1,
    REG_LINE  = 2'd2,
    REG_COUNT = 2'd3
  } irqc_reg_e;

  localparam int unsigned DEF_LINES  = 32;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_CNT_W  = 32;
  localparam int unsigned DEF_SYNC   = 2;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] shift_q;
  logic [1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_sync_no = shift_q[1];

endmodule

// File: rtl/irqc_line_sync.sv
module irqc_line_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] line_o,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] line_q;
  logic [WIDTH-1:0] line_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  always_comb begin
    line_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_d;
  end

  assign line_o = line_q;
  assign rise_o = stage_q[STAGES-1] & ~line_q;

endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] line_i,
  input  logic             mask_we_i,
  input  logic             ack_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] pend_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] mask_q, mask_d;
  logic [WIDTH-1:0] pend_q, pend_d;
  logic [WIDTH-1:0] ack_vec;
  logic             irq_q, irq_d;
  logic             mask_en;

  always_comb begin
    mask_en = mask_we_i;
    mask_d  = wdata_i;
    ack_vec = ack_we_i ? wdata_i : '0;
    // new assertions are merged after the clear so they win a collision
    pend_d  = (pend_q & ~ack_vec) | line_i;
    irq_d   = |(pend_d & (mask_en ? mask_d : mask_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/irqc_stats.sv
module irqc_stats #(
  parameter int unsigned LINES = 32,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] rise_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic [CNT_W-1:0] sel_cnt_o
);

  logic [CNT_W-1:0] cnt_q [LINES];
  logic [CNT_W-1:0] cnt_d [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_cnt
    always_comb begin
      cnt_d[i] = cnt_q[i] + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[i] <= '0;
      end else if (rise_i[i]) begin
        cnt_q[i] <= cnt_d[i];
      end
    end
  end

  assign sel_cnt_o = cnt_q[sel_i];

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NUM_LINES = irqc_pkg::DEF_LINES,
  parameter int unsigned DATA_W    = irqc_pkg::DEF_DATA_W,
  parameter int unsigned CNT_W     = irqc_pkg::DEF_CNT_W,
  parameter int unsigned SYNC_STG  = irqc_pkg::DEF_SYNC
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_LINES-1:0]         irq_lines_i,
  input  logic                         reg_we_i,
  input  logic [1:0]                   reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  input  logic [$clog2(NUM_LINES)-1:0] cnt_idx_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic                         irq_o
);

  import irqc_pkg::*;

  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] line_w;
  logic [NUM_LINES-1:0] rise_w;
  logic [NUM_LINES-1:0] mask_w;
  logic [NUM_LINES-1:0] pend_w;
  logic [CNT_W-1:0]     cnt_rd_w;
  logic                 mask_we;
  logic                 ack_we;

  irqc_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  irqc_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i (irq_lines_i),
    .line_o  (line_w),
    .rise_o  (rise_w)
  );

  always_comb begin
    mask_we = reg_we_i && (reg_addr_i == REG_MASK);
    ack_we  = reg_we_i && (reg_addr_i == REG_PEND);
  end

  irqc_core #(.WIDTH(NUM_LINES)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .line_i    (line_w),
    .mask_we_i (mask_we),
    .ack_we_i  (ack_we),
    .wdata_i   (reg_wdata_i[NUM_LINES-1:0]),
    .mask_o    (mask_w),
    .pend_o    (pend_w),
    .irq_o     (irq_o)
  );

  irqc_stats #(.LINES(NUM_LINES), .CNT_W(CNT_W)) u_stats (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .rise_i    (rise_w),
    .sel_i     (cnt_idx_i),
    .sel_cnt_o (cnt_rd_w)
  );

  always_comb begin
    unique case (reg_addr_i)
      REG_MASK:  reg_rdata_o = DATA_W'(mask_w);
      REG_PEND:  reg_rdata_o = DATA_W'(pend_w);
      REG_LINE:  reg_rdata_o = DATA_W'(line_w);
      default:   reg_rdata_o = DATA_W'(cnt_rd_w);
    endcase
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned N     = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 we,
  input logic [1:0]           addr,
  input logic [DW-1:0]        wdata,
  input logic [$clog2(N)-1:0] idx,
  input logic [N-1:0]         line,
  input logic [N-1:0]         rise,
  input logic [N-1:0]         mask,
  input logic [N-1:0]         pend,
  input logic [CNT_W-1:0]     cnt_rd,
  input logic                 irq
);

  // R5: registered request agrees with registered pending and mask
  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(pend & mask));

  // R2: without an acknowledge no pending bit drops
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 2'd1) |=> ((pend & $past(pend)) == $past(pend)));

  // R3: acknowledged bits with a low line are cleared
  p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd1) |=> ((pend & $past(wdata[N-1:0]) & ~$past(line)) == '0));

  // R4: a high line is pending one edge later whatever was written
  p_relatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(line)) == $past(line)));

  // R6: a mask write loads the whole word
  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd0) |=> (mask == $past(wdata[N-1:0])));

  // R9: no mask change without a mask write
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 2'd0) |=> $stable(mask));

  // R8: the selected counter steps by one on each rise of its line
  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(idx) |-> (cnt_rd == $past(cnt_rd) + CNT_W'($past(rise[idx]))));

endmodule

bind irqc_top irqc_checker #(.N(NUM_LINES), .DW(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_sync_n),
  .we     (reg_we_i),
  .addr   (reg_addr_i),
  .wdata  (reg_wdata_i),
  .idx    (cnt_idx_i),
  .line   (line_w),
  .rise   (rise_w),
  .mask   (mask_w),
  .pend   (pend_w),
  .cnt_rd (cnt_rd_w),
  .irq    (irq_o)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] mask;
    logic [31:0] ack;
    logic [31:0] pend;
    logic        irq;
  } vec_t;

  // applied in order; pending accumulates across entries
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h0000_0005, 32'h0000_0000, 32'h0000_0000, 32'h0000_0005, 1'b0},
    '{32'h0000_0000, 32'h0000_0004, 32'h0000_0000, 32'h0000_0005, 1'b1},
    '{32'h0000_0000, 32'h0000_0004, 32'h0000_0004, 32'h0000_0001, 1'b0},
    '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0001, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{32'hFFFF_0000, 32'h0001_0000, 32'h0000_0000, 32'hFFFF_0000, 1'b1},
    '{32'h0000_0000, 32'h0000_FFFF, 32'h0000_0000, 32'hFFFF_0000, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] lines;
  logic        we;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [4:0]  idx;
  logic [31:0] rdata;
  logic        irq;

  int checks;
  int fails;
  logic [31:0] rv;

  irqc_top uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_lines_i (lines),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .cnt_idx_i   (idx),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [4:0] i, output logic [31:0] v);
    @(negedge clk);
    addr = a; idx = i;
    #1 v = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; lines = '0; we = 1'b0; addr = 2'd0; wdata = '0; idx = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R7 reset state
    rd(2'd0, 5'd0, rv); check("R7 mask", rv, 32'h0);
    rd(2'd1, 5'd0, rv); check("R7 pend", rv, 32'h0);
    rd(2'd2, 5'd0, rv); check("R7 line", rv, 32'h0);
    rd(2'd3, 5'd9, rv); check("R7 count", rv, 32'h0);
    check("R7 irq", {31'b0, irq}, 32'h0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      lines = VECS[v].lines;
      wait_cyc(5);
      rd(2'd2, 5'd0, rv); check("R1 line state", rv, VECS[v].lines);
      wr(2'd0, VECS[v].mask);
      wr(2'd1, VECS[v].ack);
      wait_cyc(4);
      rd(2'd1, 5'd0, rv); check("R2/R3/R4 pending", rv, VECS[v].pend);
      rd(2'd0, 5'd0, rv); check("R6 mask readback", rv, VECS[v].mask);
      check("R5 irq", {31'b0, irq}, {31'b0, VECS[v].irq});
    end

    // R6: request follows a mask write on the very next edge
    @(negedge clk);
    addr = 2'd0; wdata = 32'h0001_0000; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    check("R6 irq after mask write", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0);
    check("R6 irq after mask clear", {31'b0, irq}, 32'h0);

    // R9: writes to line-state and counter addresses are ignored
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd3, 32'h1234_5678);
    rd(2'd0, 5'd0, rv);  check("R9 mask unchanged", rv, 32'h0);
    rd(2'd1, 5'd0, rv);  check("R9 pend unchanged", rv, 32'hFFFF_0000);
    rd(2'd2, 5'd0, rv);  check("R9 line unchanged", rv, 32'h0);
    rd(2'd3, 5'd31, rv); check("R9 count unchanged", rv, 32'd2);

    // R8: counters count rising edges regardless of mask
    rd(2'd3, 5'd0, rv);  check("R8 count line0", rv, 32'd1);
    rd(2'd3, 5'd17, rv); check("R8 count masked line17", rv, 32'd1);
    rd(2'd3, 5'd5, rv);  check("R8 count idle line5", rv, 32'd0);

    // R10: one-clock pulse on line 7, acknowledge on the capture edge
    @(negedge clk); lines = 32'h0000_0080;   // before e0
    @(negedge clk); lines = 32'h0;           // before e1
    @(negedge clk);                          // before e2: line state rises at e2
    @(negedge clk);                          // before e3: pending captures at e3
    addr = 2'd1; wdata = 32'h0000_0080; we = 1'b1;
    @(negedge clk); we = 1'b0;
    wait_cyc(3);
    rd(2'd1, 5'd0, rv); check("R10 pending survives collision", rv & 32'h80, 32'h80);
    rd(2'd3, 5'd7, rv); check("R8 count pulse line7", rv, 32'd1);
    wr(2'd1, 32'h0000_0080);
    rd(2'd1, 5'd0, rv); check("R3 later ack clears", rv & 32'h80, 32'h0);

    // R7: reset in the middle of a run
    wr(2'd0, 32'hFFFF_FFFF);
    check("R5 irq with pending unmasked", {31'b0, irq}, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R7 irq in reset", {31'b0, irq}, 32'h0);
    rd(2'd0, 5'd0, rv);  check("R7 mask in reset", rv, 32'h0);
    rd(2'd1, 5'd0, rv);  check("R7 pend in reset", rv, 32'h0);
    rd(2'd3, 5'd31, rv); check("R7 count in reset", rv, 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule